// File: doc/BRIEF.md
# Latched Channel-Select Controller with Break-Before-Make

This block is the digital front end of an analog multiplexer. A processor bus writes a channel address and an enable bit into a storage register. The block decodes the stored value into one-hot drive signals for the analog switches. The switches themselves, level shifting and electrical thresholds are outside the block.

The write strobe `wr_n` is active low, and the storage follows the bus for as long as it is held low. When the strobe returns high, the last value present stays in storage. The master clear `clear_n` empties the storage whatever the strobe does. A stored enable of 0 turns every switch off, so several controllers can share one analog output. Whenever the selection moves from one channel to another, the drive outputs are held all-zero for a programmable number of clock cycles before the new channel turns on.

A compile-time parameter picks the output mode:
- **Single-ended mode:** eight independent switches.
- **Differential mode:** four switch pairs. The a-side of a pair sits in the low nibble of `sw_drv` and the b-side in the high nibble.

Both `wr_n` and `clear_n` are asynchronous to the system clock and pass through two-flop synchronizers.

Top module: `chsel_ctrl`

## Requirements
- R1: While the synchronized write strobe is low and clear is inactive, the storage register takes `{en, addr}` on every rising clock edge, so the drive outputs follow the bus inputs.
- R2: While the synchronized write strobe is high, changes on `addr` and `en` have no effect on the storage or on `sw_drv`.
- R3: `clear_n` low empties the storage regardless of `wr_n`. All `sw_drv` bits are 0 by the fourth rising edge after `clear_n` falls. The outputs stay 0 after `clear_n` rises until a write stores `en` = 1.
- R4: A stored `en` of 0 drives `sw_drv` to all zeros on the next clock edge, with no break-before-make gap.
- R5: In single-ended mode (`DIFF_MODE` = 0) with `en` = 1, address value k (0..7) drives only `sw_drv[k]`. Value 0 selects the first switch and value 7 the last.
- R6: In differential mode (`DIFF_MODE` = 1) with `en` = 1, `addr[1:0]` = p drives exactly `sw_drv[p]` (a-side) and `sw_drv[p+4]` (b-side), and `addr[2]` is ignored.
- R7: No cycle ever shows more than one channel or pair driven. When the output moves from one non-zero selection to another, it is all zero for exactly `DEAD_CYCLES` cycles in between.
- R8: `rst` is an active-high synchronous reset. It empties the storage and zeroes `sw_drv` at the next clock edge, and the outputs stay 0 after release until a write with `en` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_n | input | 1 | Asynchronous active-low master clear of the storage |
| wr_n | input | 1 | Asynchronous active-low write strobe; storage is transparent while low |
| addr | input | 3 | Channel address from the bus |
| en | input | 1 | Enable bit stored with the address |
| sw_drv | output | 8 | One-hot switch drive (in differential mode: a-side in [3:0], b-side in [7:4]) |

## Verification
The interesting overlap is a master clear that arrives while the write strobe is still held low. In that cycle the transparent load and the clear both try to act on the storage. The bench keeps a valid channel on the bus with the strobe low, then pulls the clear low. It judges that `sw_drv` is zero by the fourth edge and stays zero after the clear is released with the strobe high. A second overlap is an enable-off written during a break-before-make gap. The bench measures the zero run between any two driven selections against `DEAD_CYCLES`.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    localparam int ADDR_W = 3;
    localparam int NUM_SW = 1 << ADDR_W;
    localparam int PAIRS  = NUM_SW / 2;

    typedef logic [NUM_SW-1:0] drive_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } sel_t;

    // Decode a stored selection into switch drives.
    function automatic drive_t decode_sel(sel_t s, bit diff);
        drive_t v;
        v = '0;
        if (s.en) begin
            if (diff) begin
                v[{1'b0, s.addr[ADDR_W-2:0]}] = 1'b1;
                v[{1'b1, s.addr[ADDR_W-2:0]}] = 1'b1;
            end else begin
                v[s.addr] = 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= RST_VAL;
            else     stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/chsel_store.sv
module chsel_store
    import chsel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  sel_t d,
    output sel_t q
);
    sel_t q_r;

    always_ff @(posedge clk) begin
        if (rst || clr) q_r <= '0;
        else if (load)  q_r <= d;
    end

    assign q = q_r;
endmodule

// File: rtl/chsel_bbm.sv
module chsel_bbm #(
    parameter int W           = 8,
    parameter int DEAD_CYCLES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] target,
    output logic [W-1:0] drive
);
    localparam int            CW     = $clog2(DEAD_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYCLES - 1);

    logic [W-1:0]  drv_q;
    logic [CW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= '0;
            gap_q <= '0;
        end else if (drv_q != '0 && drv_q != target) begin
            // Break first: everything off, then count the gap.
            drv_q <= '0;
            gap_q <= RELOAD;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - CW'(1);
        end else begin
            drv_q <= target;
        end
    end

    assign drive = drv_q;
endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl
    import chsel_pkg::*;
#(
    parameter bit DIFF_MODE   = 1'b0,
    parameter int DEAD_CYCLES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic [NUM_SW-1:0] sw_drv
);
    logic [1:0] ctl_s;
    logic       wr_s;
    logic       clear_s;
    sel_t       bus_sel;
    sel_t       stored;
    drive_t     target;

    // Reset state: strobe idle (1), clear asserted (0).
    chsel_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wr_n, clear_n}),
        .q   (ctl_s)
    );

    assign wr_s    = ctl_s[1];
    assign clear_s = ctl_s[0];

    assign bus_sel.en   = en;
    assign bus_sel.addr = addr;

    chsel_store u_store (
        .clk  (clk),
        .rst  (rst),
        .clr  (!clear_s),
        .load (!wr_s),
        .d    (bus_sel),
        .q    (stored)
    );

    assign target = decode_sel(stored, DIFF_MODE);

    chsel_bbm #(
        .W           (NUM_SW),
        .DEAD_CYCLES (DEAD_CYCLES)
    ) u_bbm (
        .clk    (clk),
        .rst    (rst),
        .target (target),
        .drive  (sw_drv)
    );
endmodule

// File: rtl/chsel_chk.sv
module chsel_chk
    import chsel_pkg::*;
#(
    parameter bit DIFF_MODE   = 1'b0,
    parameter int DEAD_CYCLES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              clear_s,
    input logic              wr_s,
    input logic [ADDR_W-1:0] addr,
    input logic              en,
    input sel_t              stored,
    input logic [NUM_SW-1:0] sw
);
    localparam int            ZW  = $clog2(DEAD_CYCLES + 1);
    localparam logic [ZW-1:0] SAT = ZW'(DEAD_CYCLES);

    logic [ZW-1:0] zrun;

    always_ff @(posedge clk) begin
        if (rst)           zrun <= SAT;
        else if (sw != '0) zrun <= '0;
        else if (zrun != SAT) zrun <= zrun + ZW'(1);
    end

    // R1: transparent load while strobe low
    a_r1_transparent: assert property (@(posedge clk) disable iff (rst)
        (!wr_s && clear_s) |=> (stored == $past({en, addr})));

    // R2: storage frozen while strobe high
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_s && clear_s) |=> $stable(stored));

    // R3: clear reaches the outputs two edges later
    a_r3_clear_off: assert property (@(posedge clk) disable iff (rst)
        !clear_s |-> ##2 (sw == '0));

    // R4: disabled selection turns all off with no gap
    a_r4_en_off: assert property (@(posedge clk) disable iff (rst)
        !stored.en |=> (sw == '0));

    // R7: never a direct hop between two driven selections
    a_r7_no_direct: assert property (@(posedge clk) disable iff (rst)
        (sw != '0 && $past(sw) != '0) |-> (sw == $past(sw)));

    // R7: turn-on only after a full gap
    a_r7_gap: assert property (@(posedge clk) disable iff (rst)
        (sw != '0 && $past(sw) == '0) |-> (zrun == SAT));

    if (DIFF_MODE) begin : g_diff
        // R6/R7: one pair, a and b sides together
        a_r7_single_pair: assert property (@(posedge clk) disable iff (rst)
            $onehot0(sw[PAIRS-1:0]) && (sw[NUM_SW-1:PAIRS] == sw[PAIRS-1:0]));
    end else begin : g_se
        // R7: at most one switch
        a_r7_single: assert property (@(posedge clk) disable iff (rst)
            $onehot0(sw));
    end
endmodule

bind chsel_ctrl chsel_chk #(
    .DIFF_MODE   (DIFF_MODE),
    .DEAD_CYCLES (DEAD_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clear_s (clear_s),
    .wr_s    (wr_s),
    .addr    (addr),
    .en      (en),
    .stored  (stored),
    .sw      (sw_drv)
);

// File: tb/chsel_ctrl_test.sv
module chsel_ctrl_test;
    localparam int DEAD = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clear_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic       en = 1'b0;
    logic [7:0] sw_se;
    logic [7:0] sw_df;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    chsel_ctrl #(.DIFF_MODE(1'b0), .DEAD_CYCLES(DEAD)) uut (
        .clk(clk), .rst(rst), .clear_n(clear_n), .wr_n(wr_n),
        .addr(addr), .en(en), .sw_drv(sw_se));

    chsel_ctrl #(.DIFF_MODE(1'b1), .DEAD_CYCLES(DEAD)) uut_diff (
        .clk(clk), .rst(rst), .clear_n(clear_n), .wr_n(wr_n),
        .addr(addr), .en(en), .sw_drv(sw_df));

    // {addr, en, expected single-ended, expected differential}
    localparam logic [19:0] VEC [8] = '{
        20'b000_1_00000001_00010001,  // R5 first switch, R6 pair 0
        20'b011_1_00001000_10001000,
        20'b111_1_10000000_10001000,  // R6 addr[2] ignored
        20'b100_1_00010000_00010001,
        20'b010_0_00000000_00000000,  // R4 disabled
        20'b101_1_00100000_00100010,
        20'b110_1_01000000_01000100,
        20'b001_1_00000010_00100010
    };

    // Zero-run monitor for R7.
    logic [7:0] prev_sw = '0;
    int  zrun      = 0;
    int  last_gap  = -1;
    int  direct_sw = 0;
    bit  seen_on   = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            prev_sw = '0;
            seen_on = 1'b0;
            zrun    = 0;
        end else begin
            if (sw_se == '0) begin
                zrun++;
            end else begin
                if (prev_sw == '0 && seen_on) last_gap = zrun;
                if (prev_sw != '0 && sw_se != prev_sw) direct_sw++;
                zrun    = 0;
                seen_on = 1'b1;
            end
            prev_sw = sw_se;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [2:0] a, input logic e);
        @(negedge clk);
        addr = a;
        en   = e;
        wait_cyc(2);
        wr_n = 1'b0;
        wait_cyc(30);
        wr_n = 1'b1;
        wait_cyc(4);
    endtask

    task automatic finish_run;
        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R8: reset state
        wait_cyc(5);
        chk("R8 reset se", sw_se, 8'h00);
        chk("R8 reset diff", sw_df, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        wait_cyc(12);
        chk("R8 off after release", sw_se, 8'h00);

        // R5/R6/R4: vector walk
        for (int i = 0; i < 8; i++) begin
            do_write(VEC[i][19:17], VEC[i][16]);
            wait_cyc(10);
            chk("R5 single-ended decode", sw_se, VEC[i][15:8]);
            chk("R6 differential decode", sw_df, VEC[i][7:0]);
        end

        // R7: direct channel change measured gap
        do_write(3'd1, 1'b1);
        wait_cyc(10);
        last_gap  = -1;
        direct_sw = 0;
        do_write(3'd6, 1'b1);
        wait_cyc(10);
        chk("R7 new channel", sw_se, 8'b0100_0000);
        chk_int("R7 gap length", last_gap, DEAD);
        chk_int("R7 direct hops", direct_sw, 0);

        // R2: bus changes with strobe high are ignored
        @(negedge clk);
        addr = 3'd2;
        en   = 1'b0;
        wait_cyc(20);
        chk("R2 hold se", sw_se, 8'b0100_0000);
        chk("R2 hold diff", sw_df, 8'b0100_0100);

        // R1: transparent following while strobe low
        @(negedge clk);
        addr = 3'd3;
        en   = 1'b1;
        wr_n = 1'b0;
        wait_cyc(12);
        chk("R1 follow first", sw_se, 8'b0000_1000);
        addr = 3'd5;
        wait_cyc(12);
        chk("R1 follow second", sw_se, 8'b0010_0000);

        // R3: clear while strobe still low
        clear_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R3 clear by fourth edge", sw_se, 8'h00);
        chk("R3 clear diff", sw_df, 8'h00);
        wr_n = 1'b1;
        wait_cyc(10);
        clear_n = 1'b1;
        wait_cyc(20);
        chk("R3 off after clear release", sw_se, 8'h00);
        do_write(3'd4, 1'b1);
        wait_cyc(10);
        chk("R3 recover by write", sw_se, 8'b0001_0000);

        // R4: disable then re-enable same channel keeps a gap
        last_gap = -1;
        do_write(3'd4, 1'b0);
        chk("R4 disable off", sw_se, 8'h00);
        do_write(3'd4, 1'b1);
        wait_cyc(10);
        chk("R4 re-enable", sw_se, 8'b0001_0000);
        total++;
        if (last_gap < DEAD) begin
            fails++;
            $display("FAIL R7 gap after re-enable: got %0d expected >= %0d", last_gap, DEAD);
        end

        // R8: reset mid-operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 sync reset", sw_se, 8'h00);
        rst = 1'b0;
        wait_cyc(15);
        chk("R8 stays off", sw_se, 8'h00);
        chk("R8 stays off diff", sw_df, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule